// File: doc/BRIEF.md
# Synchronous Dual-Port Memory with Same-Word Arbitration

This block is a word-addressed storage array reached through two independent synchronous ports, A and B. Each port carries its own enable, write enable, address, write data and registered read data. It also carries a per-port read-during-write mode that is captured while reset is held. When both ports work on different words, both accesses complete in the same clock cycle. When both ports touch the same word in one cycle and at least one of them writes, the block treats this as a conflict.

A conflict is settled inside the cycle in which it happens. Port A always proceeds. Port B's access is dropped, and B sees `b_busy` high in that same cycle, so the requester behind B holds its request and issues it again. One cycle later the `collision` output reports the conflict. A typical use puts a processor on port A and a DMA engine on port B.

Top module: `dpram_arb`

## Requirements
- R1: Accesses by A and B to different addresses in the same cycle both take effect: reads return stored data and writes are stored.
- R2: In mode 2'b00 (write-first), a write stores the data, and the port's read output shows the written data one cycle later.
- R3: In mode 2'b01 (read-first), a write presents the word's previous contents on the port's read output, and the new data is stored.
- R4: In mode 2'b10 (no-change), a write request leaves the stored word untouched, and the read output returns the old contents.
- R5: Read data appears one clock after an enabled access. When a port is not enabled, its read output keeps its value. Synchronous reset clears both read outputs to zero and leaves the array contents unchanged.
- R6: A conflict exists when both ports are enabled, the addresses are equal and at least one port writes. During such a cycle `b_busy` is high, and port B's access has no effect: no store, and its read output holds.
- R7: Port A's access is always performed in a conflict, and `a_busy` is never raised.
- R8: `collision` is high in exactly the cycle after each conflict cycle and is low otherwise. Back-to-back conflicts give back-to-back flag cycles.
- R9: Reads by both ports of the same address are not a conflict. Both ports return the stored word, and `b_busy` stays low.
- R10: When B's read is blocked by A's write to the same word, B's retry on the next cycle returns A's new data.
- R11: The port modes are sampled only while `rst_n` is low. A change on `a_mode` or `b_mode` after reset has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset; modes are captured while it is low |
| a_mode | input | 2 | Port A read-during-write mode (00 write-first, 01 read-first, 10 no-change) |
| b_mode | input | 2 | Port B read-during-write mode, same encoding |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write request |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| a_busy | output | 1 | Port A stall indication (never raised, A has priority) |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write request |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| b_busy | output | 1 | Port B stalled this cycle; retry the access |
| collision | output | 1 | One-cycle report of the conflict in the previous cycle |

## Verification
The bench sets up each conflict type separately: A writes while B reads, both ports write, and A reads while B writes. It also covers the same-address double read that must not count as a conflict. A design that let B through would corrupt A's word or return stale data on B's retry. A design that flagged double reads would stall B for no reason. Each mode is checked against data written earlier, so a read-first port that echoed new data, or a no-change port that still stored its data, shows up as a mismatch. Mode inputs are toggled after reset to catch a design that samples them continuously. Back-to-back conflicts catch a collision flag that is only pulsed once.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int NPORT = 2;

    typedef enum logic [1:0] {
        MODE_WF = 2'b00,
        MODE_RF = 2'b01,
        MODE_NC = 2'b10
    } rdw_mode_e;

    typedef enum logic {
        ARB_CLEAR    = 1'b0,
        ARB_COLLIDED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en_i,
    input  logic              a_we_i,
    input  logic [ADDR_W-1:0] a_addr_i,
    input  logic              b_en_i,
    input  logic              b_we_i,
    input  logic [ADDR_W-1:0] b_addr_i,
    output logic [NPORT-1:0]  grant_o,
    output logic [NPORT-1:0]  busy_o,
    output logic              collision_o
);

    arb_state_e state_q, state_d;
    logic       conflict;

    assign conflict = a_en_i && b_en_i && (a_addr_i == b_addr_i) && (a_we_i || b_we_i);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_CLEAR;
        else        state_q <= state_d;
    end

    // next state: every conflict cycle is followed by one COLLIDED cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_CLEAR:    state_d = conflict ? ARB_COLLIDED : ARB_CLEAR;
            ARB_COLLIDED: state_d = conflict ? ARB_COLLIDED : ARB_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        grant_o     = '1;
        busy_o      = '0;
        collision_o = 1'b0;
        if (conflict) begin
            grant_o[1] = 1'b0;
            busy_o[1]  = 1'b1;
        end
        unique case (state_q)
            ARB_CLEAR:    collision_o = 1'b0;
            ARB_COLLIDED: collision_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
    import dpram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       en_i,
    input  logic       we_i,
    input  logic       grant_i,
    output logic       acc_o,
    output logic       wr_o,
    output logic       byp_o
);

    logic [1:0] mode_q;

    // mode captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_i;
    end

    always_comb begin
        acc_o = en_i && grant_i;
        wr_o  = 1'b0;
        byp_o = 1'b0;
        unique case (mode_q)
            MODE_RF: begin
                wr_o  = acc_o && we_i;
                byp_o = 1'b0;
            end
            MODE_NC: begin
                wr_o  = 1'b0;
                byp_o = 1'b0;
            end
            default: begin
                wr_o  = acc_o && we_i;
                byp_o = acc_o && we_i;
            end
        endcase
    end

endmodule

// File: rtl/dpram_store.sv
module dpram_store
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              acc_i,
    input  logic [NPORT-1:0]              wr_i,
    input  logic [NPORT-1:0]              byp_i,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr_i,
    input  logic [NPORT-1:0][DATA_W-1:0]  wdata_i,
    output logic [NPORT-1:0][DATA_W-1:0]  rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (wr_i[p]) mem[addr_i[p]] <= wdata_i[p];
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)         rdata_o[p] <= '0;
            else if (acc_i[p])  rdata_o[p] <= byp_i[p] ? wdata_i[p] : mem[addr_i[p]];
        end
    end

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        a_mode,
    input  logic [1:0]        b_mode,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_busy,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_busy,
    output logic              collision
);

    logic [NPORT-1:0]              grant, busy, acc, wr, byp, en_v, we_v;
    logic [NPORT-1:0][1:0]         mode_v;
    logic [NPORT-1:0][ADDR_W-1:0]  addr_v;
    logic [NPORT-1:0][DATA_W-1:0]  wdata_v, rdata_v;

    assign en_v    = {b_en, a_en};
    assign we_v    = {b_we, a_we};
    assign mode_v  = {b_mode, a_mode};
    assign addr_v  = {b_addr, a_addr};
    assign wdata_v = {b_wdata, a_wdata};

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .a_en_i      (a_en),
        .a_we_i      (a_we),
        .a_addr_i    (a_addr),
        .b_en_i      (b_en),
        .b_we_i      (b_we),
        .b_addr_i    (b_addr),
        .grant_o     (grant),
        .busy_o      (busy),
        .collision_o (collision)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpram_port_ctl u_ctl (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_i  (mode_v[p]),
            .en_i    (en_v[p]),
            .we_i    (we_v[p]),
            .grant_i (grant[p]),
            .acc_o   (acc[p]),
            .wr_o    (wr[p]),
            .byp_o   (byp[p])
        );
    end

    dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_i   (acc),
        .wr_i    (wr),
        .byp_i   (byp),
        .addr_i  (addr_v),
        .wdata_i (wdata_v),
        .rdata_o (rdata_v)
    );

    assign a_rdata = rdata_v[0];
    assign b_rdata = rdata_v[1];
    assign a_busy  = busy[0];
    assign b_busy  = busy[1];

endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        a_mode,
    input logic              a_en,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_wdata,
    input logic [DATA_W-1:0] a_rdata,
    input logic              b_en,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_busy,
    input logic              collision
);

    logic [1:0] a_mode_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) a_mode_seen <= a_mode;
    end

    // R6: only an enabled port B can be stalled
    p_busy_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_busy |-> b_en);

    // R6: a stalled port B keeps its read output
    p_blocked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_busy |=> $stable(b_rdata));

    // R8: every stall is reported on the flag one cycle later
    p_busy_then_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        b_busy |=> collision);

    // R8: the flag never appears without a stall in the cycle before
    p_flag_had_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> $past(b_busy));

    // R9: two reads never stall port B
    p_same_reads_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && !a_we && !b_we) |-> !b_busy);

    // R2: write-first echoes the written word
    p_wf_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && a_mode_seen == 2'b00) |=> (a_rdata == $past(a_wdata)));

    // R5: an idle port holds its read data
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en && $past(rst_n)) |=> $stable(a_rdata));

endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_mode    (a_mode),
    .a_en      (a_en),
    .a_we      (a_we),
    .a_addr    (a_addr),
    .a_wdata   (a_wdata),
    .a_rdata   (a_rdata),
    .b_en      (b_en),
    .b_we      (b_we),
    .b_addr    (b_addr),
    .b_rdata   (b_rdata),
    .b_busy    (b_busy),
    .collision (collision)
);

// File: tb/test_dpram_arb.sv
`timescale 1ns/1ps
module test_dpram_arb;

    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    a_mode, b_mode;
    logic          a_en, a_we, b_en, b_we;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic          a_busy, b_busy, collision;

    always #2 clk = ~clk;

    dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_arb (
        .clk(clk), .rst_n(rst_n), .a_mode(a_mode), .b_mode(b_mode),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_busy(a_busy),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_busy(b_busy), .collision(collision)
    );

    typedef struct {
        string         tag;
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        logic          ec;
    } item_t;

    item_t         sb_q[$];
    logic [DW-1:0] mm [1<<AW];
    logic [DW-1:0] ra, rb;
    logic [1:0]    ma, mb;
    int            n_run  = 0;
    int            n_fail = 0;
    bit            done   = 0;

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle of results
    always @(negedge clk) begin
        item_t it;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            chk(it.tag, "a_rdata", a_rdata, it.ea);
            chk(it.tag, "b_rdata", b_rdata, it.eb);
            chk(it.tag, "collision", {15'd0, collision}, {15'd0, it.ec});
        end
    end

    // model of one port access, from the requirements
    task automatic port_model(input logic [1:0] m, input logic w, input logic [AW-1:0] ad,
                              input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                              output logic st);
        st = 1'b0;
        rd = mm[ad];
        if (w) begin
            case (m)
                2'b01: st = 1'b1;
                2'b10: st = 1'b0;
                default: begin st = 1'b1; rd = wd; end
            endcase
        end
    endtask

    task automatic step(input logic ae, input logic aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                        input logic be, input logic bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                        input string tag);
        item_t         it;
        logic          conf, sa, sb;
        logic [DW-1:0] na, nb;
        @(negedge clk);
        a_en = ae; a_we = aw; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bw; b_addr = ba; b_wdata = bd;
        #1;
        conf = ae && be && (aa == ba) && (aw || bw);
        chk(tag, "b_busy", {15'd0, b_busy}, {15'd0, conf});
        chk(tag, "a_busy (R7)", {15'd0, a_busy}, 16'd0);
        na = ra; nb = rb; sa = 1'b0; sb = 1'b0;
        if (ae) port_model(ma, aw, aa, ad, na, sa);
        if (be && !conf) port_model(mb, bw, ba, bd, nb, sb);
        if (sa) mm[aa] = ad;
        if (sb) mm[ba] = bd;
        ra = na; rb = nb;
        it.tag = tag; it.ea = ra; it.eb = rb; it.ec = conf;
        sb_q.push_back(it);
    endtask

    task automatic idle(input string tag);
        step(0, 0, '0, '0, 0, 0, '0, '0, tag);
    endtask

    task automatic do_reset(input logic [1:0] am, input logic [1:0] bm);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        a_en = 0; b_en = 0; a_we = 0; b_we = 0;
        a_mode = am; b_mode = bm;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ma = am; mb = bm; ra = '0; rb = '0;
        #1;
        chk("R5 reset", "a_rdata", a_rdata, '0);
        chk("R5 reset", "b_rdata", b_rdata, '0);
        chk("R8 reset", "collision", {15'd0, collision}, 16'd0);
        chk("R6 reset", "b_busy", {15'd0, b_busy}, 16'd0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b1; a_en = 0; b_en = 0; a_we = 0; b_we = 0;
        a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
        a_mode = 2'b00; b_mode = 2'b00;
        do_reset(2'b00, 2'b01);   // A write-first, B read-first

        // fill through port A (R2)
        for (int i = 0; i < 16; i++)
            step(1, 1, AW'(i), DW'(16'h1000 + i), 0, 0, '0, '0, "R2 fill");
        for (int i = 32; i < 40; i++)
            step(1, 1, AW'(i), DW'(16'h1000 + i), 0, 0, '0, '0, "R2 fill");

        // R1 / R3: A reads, B read-first writes elsewhere
        step(1, 0, 6'd3, '0, 1, 1, 6'd35, 16'hB035, "R1 R3 rd+wr");
        step(1, 0, 6'd35, '0, 1, 0, 6'd4, '0, "R1 R3 check store");
        step(1, 1, 6'd5, 16'hA005, 1, 0, 6'd6, '0, "R1 wr+rd");
        step(0, 0, '0, '0, 1, 0, 6'd5, '0, "R1 check A store");

        // R9: same-address reads
        step(1, 0, 6'd7, '0, 1, 0, 6'd7, '0, "R9 double read");

        // R6 R10: A writes, B reads same word, then retry
        step(1, 1, 6'd9, 16'hA009, 1, 0, 6'd9, '0, "R6 R10 conflict");
        step(0, 0, '0, '0, 1, 0, 6'd9, '0, "R10 retry");

        // R7: both write the same word
        step(1, 1, 6'd10, 16'hAA10, 1, 1, 6'd10, 16'hBB10, "R7 dual write");
        step(1, 0, 6'd10, '0, 0, 0, '0, '0, "R7 A won");
        step(0, 0, '0, '0, 1, 1, 6'd10, 16'hBB10, "R6 B retry write");
        step(1, 0, 6'd10, '0, 0, 0, '0, '0, "R6 B retry stored");

        // R6 R7: A reads while B writes, word unchanged
        step(1, 0, 6'd11, '0, 1, 1, 6'd11, 16'hBB11, "R6 R7 rd vs wr");
        step(1, 0, 6'd11, '0, 0, 0, '0, '0, "R6 word untouched");

        // R8: back-to-back conflicts then quiet
        step(1, 1, 6'd12, 16'hA012, 1, 0, 6'd12, '0, "R8 back-to-back 1");
        step(1, 0, 6'd13, '0, 1, 1, 6'd13, 16'hBB13, "R8 back-to-back 2");
        idle("R8 flag after second");
        idle("R8 flag low");

        // R5: idle ports hold
        idle("R5 hold");
        idle("R5 hold again");

        // R11: mode input changes after reset are ignored
        a_mode = 2'b10; b_mode = 2'b10;
        step(1, 1, 6'd14, 16'h7777, 1, 1, 6'd15, 16'h8888, "R11 modes kept");
        step(1, 0, 6'd15, '0, 1, 0, 6'd14, '0, "R11 both stored");

        // phase 2: A no-change, B write-first; memory kept over reset (R5)
        do_reset(2'b10, 2'b00);
        step(1, 0, 6'd3, '0, 1, 0, 6'd35, '0, "R5 contents kept");
        step(1, 1, 6'd12, 16'hDEAD, 0, 0, '0, '0, "R4 no-change write");
        step(0, 0, '0, '0, 1, 0, 6'd12, '0, "R4 word unchanged");
        step(1, 1, 6'd20, 16'hBEEF, 1, 1, 6'd21, 16'hB021, "R4 R2 mixed");
        step(1, 0, 6'd21, '0, 1, 0, 6'd20, '0, "R4 R2 readback");
        idle("drain");
        @(negedge clk);
        @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule